// File: doc/BRIEF.md
# Presettable Up/Down Counter with Terminal Flags

This block is a small synchronous counter. A parameter sets it to count either in plain binary over the full range of its width or in decade steps from 0 to 9. A direction input picks the counting direction, and an active-low enable lets the count advance on a rising clock edge. An active-low load input copies the preset word into the counter at once, without waiting for the clock. A synchronous active-low reset clears the count.

Two outputs support building wider counters from several copies. A terminal flag goes high for one cycle when the count stands at the end of its range for the chosen direction. A ripple-clock output, active low, is that same flag gated to the low half of the clock period. To chain stages, the next stage's enable is driven from the inverted terminal flag, and the result counts as one wider counter. In decade mode a preset value above 9 returns to the legal sequence on the next count.

The preset word is assumed to stay stable while load is low. Direction and enable are assumed to change only while the clock is high.

Top module: `updn_counter`

## Requirements
- R1: While `load_n` is low, `count` equals `preset` immediately, whatever the clock, `cnt_en_n`, `dir_dn` and `rst_n`; after `load_n` returns high the loaded value is held until the next enabled edge.
- R2: With `load_n` high and `cnt_en_n` high, `count` keeps its value across rising clock edges.
- R3: With `load_n` high and `cnt_en_n` low, each rising edge adds one to `count` when `dir_dn` is 0 and subtracts one when `dir_dn` is 1.
- R4: In binary mode (`DECADE` = 0) counting up from all ones gives 0, and counting down from 0 gives all ones.
- R5: In decade mode (`DECADE` = 1) the top value is 9: counting up from 9 gives 0, and counting down from 0 gives 9.
- R6: In decade mode a count of 10 to 15 goes to 0 on an up count and to 9 on a down count, and `term` stays low while the count holds such a value.
- R7: `term` is high exactly when `load_n` is high, `cnt_en_n` is low, and `count` is the top value with `dir_dn` = 0 or is 0 with `dir_dn` = 1.
- R8: `rco_n` is low only while `term` is high and `clk` is low. It is high for the whole high half of the clock.
- R9: With `load_n` high, a rising edge with `rst_n` low sets `count` to 0. A low `load_n` takes priority over the reset.
- R10: Two decade stages, the upper one enabled by the lower one's `term`, count together as 00 to 99. They wrap 99 to 00 going up and 00 to 99 going down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counting happens on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low, clears the count |
| load_n | input | 1 | Asynchronous parallel load, active low |
| preset | input | WIDTH | Value taken while `load_n` is low |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| count | output | WIDTH | Current count |
| term | output | 1 | Terminal flag for the selected direction |
| rco_n | output | 1 | Ripple clock, active low, `term` gated to the low clock half |

## Verification
The bench targets the range ends in both directions. A design with an off-by-one limit would skip or repeat a value, or would raise `term` one count early. It loads in the middle of the clock low phase; a design that only loads on an edge would show the old count at that moment. It presets decade values 10 to 15; a design that compares against a "greater than" limit would raise a false carry there and step the upper digit. A design that steps in binary would get stuck above 9. A chained pair checks the 99/00 carry and borrow. Reset with load held low shows whether load wins over reset.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the up/down counter.
// Assumes WIDTH >= 4 whenever decade counting is chosen.
package updn_pkg;

    // Counting direction as presented on dir_dn.
    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_dir_e;

    // Highest legal count for the chosen mode and width.
    function automatic int unsigned top_value(input bit decade, input int width);
        return decade ? 32'd9 : ((32'd1 << width) - 32'd1);
    endfunction

endpackage

// File: rtl/updn_step.sv
`timescale 1ns/1ps
// Next-count logic for one counter stage.
// Computes the value after one count in the given direction. It also
// reports whether the current value is the top or the bottom of the range.
// Assumes cur may hold an out-of-range value in decade mode.
module updn_step
    import updn_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             dir_dn,
    output logic [WIDTH-1:0] nxt,
    output logic             is_top,
    output logic             is_bottom
);

    localparam logic [WIDTH-1:0] TOP = WIDTH'(top_value(DECADE, WIDTH));
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Range-end detection, exact match only so illegal values never flag.
    always_comb begin
        is_top    = (cur == TOP);
        is_bottom = (cur == '0);
    end

    generate
        if (DECADE) begin : g_decade
            logic illegal;
            // Decade step with recovery of out-of-range values.
            always_comb begin
                illegal = (cur > TOP);
                if (cnt_dir_e'(dir_dn) == CNT_UP) begin
                    nxt = (illegal || cur == TOP) ? '0 : cur + ONE;
                end else begin
                    nxt = (illegal || cur == '0) ? TOP : cur - ONE;
                end
            end
        end else begin : g_binary
            // Binary step; the full range wraps naturally.
            always_comb begin
                if (cnt_dir_e'(dir_dn) == CNT_UP) begin
                    nxt = cur + ONE;
                end else begin
                    nxt = cur - ONE;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/updn_flags.sv
`timescale 1ns/1ps
// Terminal flag and ripple-clock generation.
// term is decoded from the present count, direction, enable and load.
// rco_n is term gated to the low half of the clock.
// Assumes direction and enable change only while the clock is high.
module updn_flags
    import updn_pkg::*;
(
    input  logic clk,
    input  logic load_n,
    input  logic cnt_en_n,
    input  logic dir_dn,
    input  logic is_top,
    input  logic is_bottom,
    output logic term,
    output logic rco_n
);

    logic at_end;

    // Pick the range end that matches the counting direction.
    always_comb begin
        at_end = (cnt_dir_e'(dir_dn) == CNT_DOWN) ? is_bottom : is_top;
    end

    // Flag only while counting is live; forced low when disabled or loading.
    always_comb begin
        term = load_n && !cnt_en_n && at_end;
    end

    // Ripple clock, active low during the low clock phase of a terminal cycle.
    always_comb begin
        rco_n = !(term && !clk);
    end

endmodule

// File: rtl/updn_state.sv
`timescale 1ns/1ps
// Count register with asynchronous parallel load and synchronous reset.
// The output follows preset directly while load_n is low, so a load is
// visible at once. Assumes preset is stable while load_n is low.
module updn_state #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset,
    input  logic             cnt_en_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] cnt_r;

    // Storage: load wins, then reset, then an enabled count.
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            cnt_r <= preset;
        end else if (!rst_n) begin
            cnt_r <= '0;
        end else if (!cnt_en_n) begin
            cnt_r <= nxt;
        end
    end

    // Output path that is transparent to preset while loading.
    always_comb begin
        q = load_n ? cnt_r : preset;
    end

endmodule

// File: rtl/updn_counter.sv
`timescale 1ns/1ps
// Presettable up/down counter with terminal flag and ripple clock.
// DECADE selects 0..9 counting; otherwise the full WIDTH-bit range.
// Stages chain by driving the next stage's cnt_en_n from !term.
module updn_counter #(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset,
    input  logic             cnt_en_n,
    input  logic             dir_dn,
    output logic [WIDTH-1:0] count,
    output logic             term,
    output logic             rco_n
);

    logic [WIDTH-1:0] nxt;
    logic             is_top;
    logic             is_bottom;

    updn_step #(.WIDTH(WIDTH), .DECADE(DECADE)) step_i (
        .cur       (count),
        .dir_dn    (dir_dn),
        .nxt       (nxt),
        .is_top    (is_top),
        .is_bottom (is_bottom)
    );

    updn_state #(.WIDTH(WIDTH)) state_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .preset   (preset),
        .cnt_en_n (cnt_en_n),
        .nxt      (nxt),
        .q        (count)
    );

    updn_flags flags_i (
        .clk       (clk),
        .load_n    (load_n),
        .cnt_en_n  (cnt_en_n),
        .dir_dn    (dir_dn),
        .is_top    (is_top),
        .is_bottom (is_bottom),
        .term      (term),
        .rco_n     (rco_n)
    );

endmodule

// File: rtl/updn_counter_chk.sv
`timescale 1ns/1ps
// Property checker for updn_counter, bound to every instance.
// Values sampled at edge N reflect the update made at edge N-1, so each
// step property relates $past inputs and count to the present count.
module updn_counter_chk
    import updn_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             cnt_en_n,
    input logic             dir_dn,
    input logic [WIDTH-1:0] count,
    input logic             term,
    input logic             rco_n
);

    localparam logic [WIDTH-1:0] TOP = WIDTH'(top_value(DECADE, WIDTH));

    logic ld_seen;

    // Remembers any load since the last edge, including one between edges.
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            ld_seen <= 1'b1;
        end else begin
            ld_seen <= 1'b0;
        end
    end

    // R2: disabled count holds
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_seen && $past(rst_n) && $past(cnt_en_n)) |-> $stable(count));

    // R3: single step up inside the range
    assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_seen && $past(rst_n) && !$past(cnt_en_n) && !$past(dir_dn)
         && $past(count) < TOP) |-> (count == $past(count) + 1'b1));

    // R3: single step down inside the range
    assert_step_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_seen && $past(rst_n) && !$past(cnt_en_n) && $past(dir_dn)
         && $past(count) != '0 && $past(count) <= TOP) |-> (count == $past(count) - 1'b1));

    // R4 and R5: wrap from the top going up
    assert_wrap_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_seen && $past(rst_n) && !$past(cnt_en_n) && !$past(dir_dn)
         && $past(count) == TOP) |-> (count == '0));

    // R4 and R5: wrap from zero going down
    assert_wrap_dn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_seen && $past(rst_n) && !$past(cnt_en_n) && $past(dir_dn)
         && $past(count) == '0) |-> (count == TOP));

    // R7: flag only while counting is live
    assert_flag_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        term |-> (load_n && !cnt_en_n));

    // R7: flag going down only at zero
    assert_flag_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (term && dir_dn) |-> (count == '0));

    // R7: flag going up only at the top
    assert_flag_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !dir_dn) |-> (count == TOP));

    // R8: in the low half the ripple clock mirrors the flag
    assert_rco_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rco_n == !term);

    // R8: ripple clock idle through the high half
    assert_rco_high_R8: assert property (@(negedge clk) disable iff (!rst_n)
        rco_n);

    // R9: reset edge with load high clears the count
    assert_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_seen && !$past(rst_n)) |-> (count == '0));

    generate
        if (DECADE) begin : g_dec_chk
            // R6: illegal decade values recover in one count
            assert_recover_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (!ld_seen && $past(rst_n) && !$past(cnt_en_n) && $past(count) > TOP)
                |-> (count == ($past(dir_dn) ? TOP : '0)));
        end
    endgenerate

endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH), .DECADE(DECADE)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .cnt_en_n (cnt_en_n),
    .dir_dn   (dir_dn),
    .count    (count),
    .term     (term),
    .rco_n    (rco_n)
);

// File: tb/updn_counter_tb_top.sv
`timescale 1ns/1ps
// Bench: one binary counter plus two chained decade stages, with shared
// controls. Expected values come from bench functions. Inputs change
// 5 ns after a rising edge; outputs are sampled in the low clock half.
module updn_counter_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic       en_n = 1'b1;
    logic       dir_dn = 1'b0;
    logic [3:0] pre_b = '0, pre_lo = '0, pre_hi = '0;

    logic [3:0] b_q, lo_q, hi_q;
    logic       b_term, lo_term, hi_term;
    logic       b_rco, lo_rco, hi_rco;
    logic       hi_en_n;

    assign hi_en_n = !lo_term;

    updn_counter #(.WIDTH(4), .DECADE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .preset(pre_b),
        .cnt_en_n(en_n), .dir_dn(dir_dn), .count(b_q), .term(b_term), .rco_n(b_rco));

    updn_counter #(.WIDTH(4), .DECADE(1'b1)) dec_lo_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .preset(pre_lo),
        .cnt_en_n(en_n), .dir_dn(dir_dn), .count(lo_q), .term(lo_term), .rco_n(lo_rco));

    updn_counter #(.WIDTH(4), .DECADE(1'b1)) dec_hi_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .preset(pre_hi),
        .cnt_en_n(hi_en_n), .dir_dn(dir_dn), .count(hi_q), .term(hi_term), .rco_n(hi_rco));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [3:0] mb = '0, mlo = '0, mhi = '0;

    // Expected value after one count, with recovery of out-of-range values.
    function automatic logic [3:0] nxt_m(input logic [3:0] v, input logic dn, input logic [3:0] lim);
        if (!dn) return (v >= lim) ? 4'd0 : v + 4'd1;
        return (v == 4'd0 || v > lim) ? lim : v - 4'd1;
    endfunction

    // Expected terminal flag.
    function automatic logic flag_m(input logic [3:0] v, input logic dn, input logic en_low,
                                    input logic ld_hi, input logic [3:0] lim);
        return ld_hi && en_low && (dn ? (v == 4'd0) : (v == lim));
    endfunction

    // One comparison with bookkeeping.
    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update at a rising edge, using the inputs present at that edge.
    task automatic edge_model();
        logic carry;
        if (!load_n) begin
            mb = pre_b; mlo = pre_lo; mhi = pre_hi;
        end else if (!rst_n) begin
            mb = '0; mlo = '0; mhi = '0;
        end else if (!en_n) begin
            carry = flag_m(mlo, dir_dn, 1'b1, 1'b1, 4'd9);
            mb = nxt_m(mb, dir_dn, 4'd15);
            if (carry) mhi = nxt_m(mhi, dir_dn, 4'd9);
            mlo = nxt_m(mlo, dir_dn, 4'd9);
        end
    endtask

    // Compare every output against the model; called while clk is low.
    task automatic check_all(input string req);
        logic eb, elo, ehi;
        eb  = flag_m(mb, dir_dn, !en_n, load_n, 4'd15);
        elo = flag_m(mlo, dir_dn, !en_n, load_n, 4'd9);
        ehi = flag_m(mhi, dir_dn, !en_n && elo, load_n, 4'd9);
        chk(req, {4'd0, b_q}, {4'd0, mb});
        chk(req, {hi_q, lo_q}, {mhi, mlo});
        chk("R7", {5'd0, b_term, lo_term, hi_term}, {5'd0, eb, elo, ehi});
        chk("R8", {5'd0, b_rco, lo_rco, hi_rco}, {5'd0, !eb, !elo, !ehi});
    endtask

    // One clock cycle: edge, new inputs while clk high, checks while clk low.
    task automatic cyc(input logic e, input logic d, input string req, input logic r = 1'b1);
        @(posedge clk);
        edge_model();
        #5;
        en_n = e; dir_dn = d; rst_n = r;
        #2;
        chk("R8", {5'd0, b_rco, lo_rco, hi_rco}, 8'h07);
        #8;
        check_all(req);
    endtask

    // Load pulse in the low clock half, between two edges.
    task automatic mid_load(input logic [3:0] b, input logic [3:0] lo, input logic [3:0] hi,
                            input string req);
        pre_b = b; pre_lo = lo; pre_hi = hi;
        load_n = 1'b0;
        #1;
        chk("R1", {4'd0, b_q}, {4'd0, b});
        chk("R1", {hi_q, lo_q}, {hi, lo});
        chk("R7", {5'd0, b_term, lo_term, hi_term}, 8'h00);
        #2;
        load_n = 1'b1;
        mb = b; mlo = lo; mhi = hi;
        #1;
        check_all(req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 60000);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        // R9: reset state
        repeat (3) cyc(1'b1, 1'b0, "R9", 1'b0);
        cyc(1'b1, 1'b0, "R9");
        // R3: up then down runs, including R4 binary wrap and R10 carries
        repeat (20) cyc(1'b0, 1'b0, "R3");
        repeat (24) cyc(1'b0, 1'b1, "R3");
        // R2: hold
        repeat (5) cyc(1'b1, 1'b0, "R2");
        repeat (3) cyc(1'b1, 1'b1, "R2");
        // R4: binary wrap downward from zero, decade 00 -> 99
        cyc(1'b0, 1'b1, "R4");
        mid_load(4'd0, 4'd0, 4'd0, "R1");
        cyc(1'b0, 1'b1, "R4");
        // R10: chained wrap 99 -> 00, binary 15 -> 0
        cyc(1'b0, 1'b0, "R10");
        mid_load(4'd15, 4'd9, 4'd9, "R1");
        cyc(1'b0, 1'b0, "R10");
        cyc(1'b0, 1'b0, "R10");
        // R10: borrow 10 -> 09
        cyc(1'b0, 1'b1, "R10");
        mid_load(4'd6, 4'd0, 4'd1, "R1");
        cyc(1'b0, 1'b1, "R10");
        // R5: decade up through 9 carries into the upper digit
        cyc(1'b0, 1'b0, "R5");
        mid_load(4'd3, 4'd9, 4'd4, "R5");
        cyc(1'b0, 1'b0, "R5");
        // R6: illegal decade values, no false carry or borrow
        mid_load(4'd7, 4'd12, 4'd3, "R6");
        cyc(1'b0, 1'b0, "R6");
        cyc(1'b0, 1'b1, "R6");
        mid_load(4'd7, 4'd14, 4'd3, "R6");
        cyc(1'b0, 1'b1, "R6");
        mid_load(4'd2, 4'd15, 4'd11, "R6");
        cyc(1'b0, 1'b0, "R6");
        cyc(1'b0, 1'b0, "R6");
        // R1 and R9: load held across edges overrides reset and enable
        pre_b = 4'd10; pre_lo = 4'd6; pre_hi = 4'd2;
        load_n = 1'b0;
        cyc(1'b0, 1'b0, "R1", 1'b0);
        cyc(1'b0, 1'b0, "R1", 1'b0);
        load_n = 1'b1;
        cyc(1'b0, 1'b0, "R9", 1'b1);
        cyc(1'b0, 1'b0, "R3");
        // R3: random mix with mid-cycle loads and occasional reset
        for (int i = 0; i < 600; i++) begin
            cyc(($urandom_range(3, 0) == 0), 1'($urandom_range(1, 0)), "R3",
                ($urandom_range(39, 0) != 0));
            if ($urandom_range(7, 0) == 0) begin
                mid_load(4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)),
                         4'($urandom_range(9, 0)), "R1");
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule